// File: doc/BRIEF.md
# SDLC Frame Transmitter with Automatic Controls

This block turns a stream of bytes written by a host into bit-oriented synchronous frames on a single serial line. Each frame is bounded by flag characters. A zero is stuffed into the data and check field after any run of five ones. A 16-bit frame check sequence is appended when the host stops supplying bytes. The line can be sent as plain NRZ or as NRZI. Every bit moves on a one-cycle bit-clock enable. Between frames the line carries either continuous flags or continuous marks.

Four independent control inputs move work from host software into hardware:
- An automatic opening flag, so the host can write the first byte at any time.
- An automatic clear of the underrun/end-of-message latch once the first byte of a frame has gone out.
- A hold on the RTS output until the closing flag has completely left the shifter.
- A forced high line level while the transmitter is disabled in NRZI mode.

With all four at 0, the host sequences these steps itself.

Top module: `sdlc_tx_auto`

## Requirements
- R1: While reset is asserted, txd is 1, buf_empty is 1, eom_latch is 1 and rts_out is 0.
- R2: A write sets buf_empty to 0 on the next clock. buf_empty returns to 1 on the clock after the bit-clock enable that moves the byte into the shifter. A write in that same cycle keeps it at 0.
- R3: A frame on the line reads, in order, as follows. Each byte is sent least-significant bit first.
  - The flag 8'h7E.
  - The data bytes.
  - The check field. It is the complement of CRC-16 (x^16+x^12+x^5+1) computed bit-serially in LSB-first order with polynomial constant 16'h8408 and a preset of 16'hFFFF. Its low byte is sent first.
  - A closing 8'h7E flag.
- R4: Inside data and check-field bits, a 0 is inserted after every five consecutive 1s. Flag and idle bits are never stuffed.
- R5: The idle output depends on idle_flags: 1 gives back-to-back 8'h7E flags, and 0 gives all 1s, in 8-bit slots. With auto_flag at 0, a written byte starts at the next slot boundary. When the line idles with flags, the last idle flag acts as the opening flag. When it idles with marks, no opening flag is sent.
- R6: With auto_flag at 1, a byte written while idle is preceded by one complete opening flag, even when idling with marks.
- R7: On an underrun (buffer empty at a byte boundary inside a frame) with eom_latch at 0, the check field and the closing flag are sent, and eom_latch sets as the closing flag begins. On an underrun with eom_latch at 1, only the closing flag follows the data.
- R8: A pulse on eom_clr clears eom_latch on the next clock.
- R9: With auto_eom_rst at 1, eom_latch clears once the last bit of the frame's first data byte has been shifted out, with no host command.
- R10: With auto_rts_off at 0, rts_out equals rts_req delayed by one clock.
- R11: With auto_rts_off at 1, rts_req may drop while the check field is being sent. In that case rts_out stays 1 through the final bit of the closing flag and falls on the next bit-clock enable.
- R12: With nrzi_en at 1, a 0 bit toggles txd and a 1 bit holds it, and the line starts at 1. A disabled transmitter (tx_enable 0) sends marks, so an NRZI line holds its level.
- R13: With force_high at 1, nrzi_en at 1 and tx_enable at 0, txd is 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| tx_enable | input | 1 | Transmitter enable; 0 sends marks and drops any frame |
| nrzi_en | input | 1 | 1 selects NRZI line coding |
| idle_flags | input | 1 | Idle fill: 1 flags, 0 marks |
| auto_flag | input | 1 | Automatic opening flag |
| auto_eom_rst | input | 1 | Automatic underrun/EOM latch clear |
| auto_rts_off | input | 1 | RTS held until closing flag is out |
| force_high | input | 1 | Force txd high when disabled in NRZI |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Transmit buffer byte |
| eom_clr | input | 1 | Host command clearing the EOM latch |
| rts_req | input | 1 | Requested RTS level |
| buf_empty | output | 1 | Transmit buffer empty |
| eom_latch | output | 1 | Underrun/end-of-message latch |
| rts_out | output | 1 | RTS line |
| txd | output | 1 | Serial data line |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, the 8'h7E flag, a stuffing run of five and the reflected CCITT constant. With these values, bytes such as 8'hFF and 8'h7E inside data force stuffing, and a computed check field can force it right before the closing flag. A bit-level model in the bench decodes NRZ or NRZI, rebuilds each expected frame independently, and locates it in the captured line together with the RTS level seen at every bit. The opening-flag, latch and RTS rules can therefore be read off single bit positions.

// File: rtl/sdlc_tx_auto.sv
module sdlc_tx_auto #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FLAG = 8'h7E,
  parameter int RUN_MAX = 5,
  parameter logic [2*BYTE_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              nrzi_en,
  input  logic              idle_flags,
  input  logic              auto_flag,
  input  logic              auto_eom_rst,
  input  logic              auto_rts_off,
  input  logic              force_high,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              eom_clr,
  input  logic              rts_req,
  output logic              buf_empty,
  output logic              eom_latch,
  output logic              rts_out,
  output logic              txd
);
  localparam int CRC_W = 2 * BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  typedef enum logic [2:0] {K_IDLE, K_OPEN, K_DATA, K_CRC1, K_CRC2, K_CLOSE} kind_e;

  logic [BYTE_W-1:0] buf_q, sh_q, nxt_byte;
  logic              full_q, first_q, eom_q, rts_q, line_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RUN_W-1:0]  run_q;
  logic [CRC_W-1:0]  crc_q, crc_base;
  kind_e             kind_q, nxt_kind, bit_kind;
  logic              take, frame_start, stuff, bound, step, tx_bit, tail, close_end;

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY : '0);
  endfunction

  assign stuff     = run_q == RUN_W'(RUN_MAX);
  assign bound     = cnt_q == '0;
  assign step      = bit_en && tx_enable && !stuff;
  assign tx_bit    = !tx_enable ? 1'b1 : stuff ? 1'b0 : bound ? nxt_byte[0] : sh_q[0];
  assign bit_kind  = bound ? nxt_kind : kind_q;
  assign tail      = kind_q inside {K_CRC1, K_CRC2, K_CLOSE};
  assign close_end = step && bound && kind_q == K_CLOSE;
  assign crc_base  = (bound && frame_start) ? '1 : crc_q;

  assign buf_empty = !full_q;
  assign eom_latch = eom_q;
  assign rts_out   = rts_q;
  assign txd       = line_q;

  always_comb begin
    nxt_kind    = K_IDLE;
    nxt_byte    = idle_flags ? FLAG : '1;
    take        = 1'b0;
    frame_start = 1'b0;
    case (kind_q)
      K_OPEN, K_DATA: begin
        if (full_q) begin
          nxt_kind = K_DATA; nxt_byte = buf_q; take = 1'b1;
        end else if (!eom_q) begin
          nxt_kind = K_CRC1; nxt_byte = ~crc_q[BYTE_W-1:0];
        end else begin
          nxt_kind = K_CLOSE; nxt_byte = FLAG;
        end
      end
      K_CRC1: begin nxt_kind = K_CRC2; nxt_byte = ~crc_q[CRC_W-1:BYTE_W]; end
      K_CRC2: begin nxt_kind = K_CLOSE; nxt_byte = FLAG; end
      default: begin
        if (full_q) begin
          frame_start = 1'b1;
          if (auto_flag) begin
            nxt_kind = K_OPEN; nxt_byte = FLAG;
          end else begin
            nxt_kind = K_DATA; nxt_byte = buf_q; take = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '1;
      cnt_q   <= '0;
      kind_q  <= K_IDLE;
      run_q   <= '0;
      crc_q   <= '1;
      first_q <= 1'b0;
      eom_q   <= 1'b1;
      rts_q   <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      rts_q <= rts_req | (auto_rts_off & rts_q & tail & !close_end);

      if (wr_en) begin
        buf_q  <= wr_data;
        full_q <= 1'b1;
      end else if (step && bound && take) begin
        full_q <= 1'b0;
      end

      if (force_high && nrzi_en && !tx_enable) line_q <= 1'b1;
      else if (bit_en) line_q <= nrzi_en ? (tx_bit ? line_q : !line_q) : tx_bit;

      if (eom_clr) eom_q <= 1'b0;
      else if (step && bound && kind_q == K_CRC2) eom_q <= 1'b1;
      else if (step && bound && kind_q == K_DATA && first_q && auto_eom_rst) eom_q <= 1'b0;

      if (bit_en) begin
        if (!tx_enable) begin
          kind_q <= K_IDLE;
          cnt_q  <= '0;
          run_q  <= '0;
        end else if (stuff) begin
          run_q <= '0;
        end else begin
          if (bound) begin
            sh_q   <= nxt_byte >> 1;
            cnt_q  <= CNT_W'(BYTE_W - 1);
            kind_q <= nxt_kind;
          end else begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
          end
          run_q <= (tx_bit && bit_kind inside {K_DATA, K_CRC1, K_CRC2}) ? run_q + 1'b1 : '0;
          if (bit_kind == K_DATA) crc_q <= crc_next(crc_base, tx_bit);
          else if (bound && frame_start) crc_q <= '1;
          if (bound && frame_start) first_q <= 1'b1;
          else if (bound && kind_q == K_DATA) first_q <= 1'b0;
        end
      end
    end
  end

  p_empty_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bound && take && !wr_en) |=> buf_empty);
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty);
  p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && tx_enable && stuff && !nrzi_en) |=> !txd);
  p_stuff_toggle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && tx_enable && stuff && nrzi_en) |=> txd != $past(txd));
  p_eom_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eom_latch) |-> $past(kind_q == K_CRC2));
  p_eom_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eom_clr |=> !eom_latch);
  p_rts_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_off |=> rts_out == $past(rts_req));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_enable && nrzi_en && !force_high) |=> $stable(txd));
  p_force_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (force_high && nrzi_en && !tx_enable) |=> txd);
endmodule

// File: tb/sdlc_tx_auto_bench.sv
module sdlc_tx_auto_bench;
  logic clk = 0, rst_n = 0, bit_en = 0, wr_en = 0, tx_enable = 0, nrzi_en = 0;
  logic idle_flags = 1, auto_flag = 0, auto_eom_rst = 0, auto_rts_off = 0;
  logic force_high = 0, eom_clr = 0, rts_req = 0;
  logic [7:0] wr_data = 0;
  logic buf_empty, eom_latch, rts_out, txd;

  sdlc_tx_auto u_sdlc_tx_auto (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable), .nrzi_en(nrzi_en),
    .idle_flags(idle_flags), .auto_flag(auto_flag), .auto_eom_rst(auto_eom_rst),
    .auto_rts_off(auto_rts_off), .force_high(force_high), .wr_en(wr_en), .wr_data(wr_data),
    .eom_clr(eom_clr), .rts_req(rts_req), .buf_empty(buf_empty), .eom_latch(eom_latch),
    .rts_out(rts_out), .txd(txd));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, ben_cnt = 0, run_s = 0, fr_n = 0;
  bit done = 0, cap_on = 0, ben_last = 0;
  logic cap_q[$], rts_cap[$], dec_q[$], exp_q[$];
  logic cap_prev = 1;
  logic [7:0] fr [0:7];

  initial forever begin
    @(negedge clk); bit_en = 1;
    @(negedge clk); bit_en = 0;
    repeat (2) @(negedge clk);
  end

  initial forever begin
    @(posedge clk);
    ben_last = bit_en;
    if (bit_en) begin
      ben_cnt++;
      #1;
      if (cap_on) begin cap_q.push_back(txd); rts_cap.push_back(rts_out); end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic start_cap();
    cap_q.delete(); rts_cap.delete();
    cap_prev = txd;
    cap_on = 1;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit stf);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      if (stf) begin
        run_s = b[i] ? run_s + 1 : 0;
        if (run_s == 5) begin exp_q.push_back(1'b0); run_s = 0; end
      end else run_s = 0;
    end
  endtask

  task automatic build(input bit with_fcs, input bit lead_flag);
    logic [15:0] c;
    logic fb;
    exp_q.delete(); run_s = 0; c = 16'hFFFF;
    push_byte(lead_flag ? 8'h7E : 8'hFF, 0);
    for (int k = 0; k < fr_n; k++) begin
      push_byte(fr[k], 1);
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ fr[k][i];
        c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
    end
    if (with_fcs) begin
      c = ~c;
      push_byte(c[7:0], 1);
      push_byte(c[15:8], 1);
    end
    push_byte(8'h7E, 0);
  endtask

  function automatic int find_frame();
    logic prev;
    bit hit;
    dec_q.delete();
    prev = cap_prev;
    for (int i = 0; i < cap_q.size(); i++) begin
      dec_q.push_back(nrzi_en ? (cap_q[i] == prev) : cap_q[i]);
      prev = cap_q[i];
    end
    for (int s = 0; s + exp_q.size() <= dec_q.size(); s++) begin
      hit = 1;
      for (int j = 0; j < exp_q.size(); j++) if (dec_q[s+j] !== exp_q[j]) hit = 0;
      if (hit) return s;
    end
    return -1;
  endfunction

  task automatic send(input bit manual_clr);
    for (int i = 0; i < fr_n; i++) begin
      while (!buf_empty) @(negedge clk);
      if (i == 1) chk(ben_last == 1, "R2 load edge", ben_last, 1);
      if (i == 2 && auto_eom_rst) chk(eom_latch == 0, "R9 auto clear", eom_latch, 0);
      wr_en = 1; wr_data = fr[i];
      @(negedge clk);
      wr_en = 0;
      if (i == 0) chk(buf_empty == 0, "R2 write", buf_empty, 0);
      if (i == 0 && manual_clr) begin
        eom_clr = 1; @(negedge clk); eom_clr = 0;
        chk(eom_latch == 0, "R8 host clear", eom_latch, 0);
      end
    end
    repeat (700) @(negedge clk);
    cap_on = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(buf_empty == 1, "R1 buf_empty", buf_empty, 1);
    chk(eom_latch == 1, "R1 eom_latch", eom_latch, 1);
    chk(rts_out == 0, "R1 rts_out", rts_out, 0);
    rst_n = 1; tx_enable = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_flags_auto_eom();
    idle_flags = 1; auto_eom_rst = 1;
    fr[0] = 8'hFF; fr[1] = 8'h1F; fr[2] = 8'h7E; fr[3] = 8'hF8; fr_n = 4;
    start_cap(); repeat (40) @(negedge clk);
    send(0);
    build(1, 1);
    chk(find_frame() >= 0, "R3 R4 R5 flag-idle frame with stuffing", find_frame(), 0);
    chk(eom_latch == 1, "R7 latch set after fcs", eom_latch, 1);
    auto_eom_rst = 0;
  endtask

  task automatic t_marks_manual();
    idle_flags = 0;
    repeat (80) @(negedge clk);
    fr[0] = 8'h3C; fr[1] = 8'hFF; fr[2] = 8'h0F; fr_n = 3;
    start_cap(); repeat (40) @(negedge clk);
    send(1);
    build(1, 0);
    chk(find_frame() >= 0, "R5 mark idle, no opening flag", find_frame(), 0);
    chk(eom_latch == 1, "R7 latch set", eom_latch, 1);
  endtask

  task automatic t_auto_flag();
    idle_flags = 0; auto_flag = 1; auto_eom_rst = 1;
    repeat (80) @(negedge clk);
    fr[0] = 8'hA5; fr[1] = 8'hFE; fr[2] = 8'h01; fr_n = 3;
    start_cap(); repeat (40) @(negedge clk);
    send(0);
    build(1, 1);
    exp_q.push_front(1'b1); exp_q.push_front(1'b1); exp_q.push_front(1'b1); exp_q.push_front(1'b1);
    chk(find_frame() >= 0, "R6 opening flag after marks", find_frame(), 0);
    auto_flag = 0; auto_eom_rst = 0; idle_flags = 1;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_no_fcs();
    idle_flags = 1;
    fr[0] = 8'h55; fr[1] = 8'hFF; fr_n = 2;
    start_cap(); repeat (40) @(negedge clk);
    send(0);
    build(0, 1);
    chk(find_frame() >= 0, "R7 latch set: closing flag only", find_frame(), 0);
    chk(eom_latch == 1, "R7 latch stays set", eom_latch, 1);
  endtask

  task automatic t_nrzi();
    nrzi_en = 1; idle_flags = 1; auto_eom_rst = 1;
    repeat (80) @(negedge clk);
    fr[0] = 8'h00; fr[1] = 8'hFF; fr[2] = 8'h7C; fr_n = 3;
    start_cap(); repeat (40) @(negedge clk);
    send(0);
    build(1, 1);
    chk(find_frame() >= 0, "R12 nrzi frame", find_frame(), 0);
    auto_eom_rst = 0;
  endtask

  task automatic t_force();
    int n0;
    nrzi_en = 1; idle_flags = 1;
    while (txd != 0) @(negedge clk);
    tx_enable = 0;
    n0 = ben_cnt;
    while (ben_cnt < n0 + 5) @(negedge clk);
    chk(txd == 0, "R12 disabled nrzi holds", txd, 0);
    force_high = 1;
    @(negedge clk);
    chk(txd == 1, "R13 forced high", txd, 1);
    force_high = 0; nrzi_en = 0; tx_enable = 1;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_rts();
    int n0, s, e;
    auto_rts_off = 0; rts_req = 1;
    @(negedge clk);
    chk(rts_out == 1, "R10 rts rise", rts_out, 1);
    rts_req = 0;
    @(negedge clk);
    chk(rts_out == 0, "R10 rts fall", rts_out, 0);
    auto_rts_off = 1; auto_eom_rst = 1; idle_flags = 1; rts_req = 1;
    fr[0] = 8'h00; fr[1] = 8'h00; fr_n = 2;
    start_cap(); repeat (40) @(negedge clk);
    wr_en = 1; wr_data = fr[0]; @(negedge clk); wr_en = 0;
    while (!buf_empty) @(negedge clk);
    wr_en = 1; wr_data = fr[1]; @(negedge clk); wr_en = 0;
    while (!buf_empty) @(negedge clk);
    n0 = ben_cnt;
    while (ben_cnt < n0 + 10) @(negedge clk);
    rts_req = 0;
    repeat (2) @(negedge clk);
    chk(rts_out == 1, "R11 rts held in fcs", rts_out, 1);
    repeat (500) @(negedge clk);
    cap_on = 0;
    build(1, 1);
    s = find_frame();
    chk(s >= 0, "R11 frame found", s, 0);
    e = s + exp_q.size() - 1;
    if (s >= 0 && e + 1 < rts_cap.size()) begin
      chk(rts_cap[e] == 1, "R11 rts at last flag bit", rts_cap[e], 1);
      chk(rts_cap[e+1] == 0, "R11 rts after flag", rts_cap[e+1], 0);
    end else chk(0, "R11 capture length", rts_cap.size(), e + 2);
    chk(rts_out == 0, "R11 rts low at end", rts_out, 0);
    auto_rts_off = 0; auto_eom_rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flags_auto_eom();
    t_marks_manual();
    t_auto_flag();
    t_no_fcs();
    t_nrzi();
    t_force();
    t_rts();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule